// File: doc/BRIEF.md
# Byte-Serial Line Transmitter

This block turns a parallel byte into an asynchronous serial frame on a single output line. A host presents a byte and pulses a one-cycle load strobe while the transmitter is idle; the byte is captured in that cycle and the busy flag rises. An external one-cycle baud tick paces the whole frame: the block never generates timing of its own, so the bit period is whatever spacing the tick source chooses.

The frame is a low start bit, the data bits with the least-significant bit first, and a high stop bit. Control is an explicit four-state machine. After capture, a preparation state builds the start-plus-data pattern into a shift register and waits for the next tick, so the start bit always begins on a tick boundary and lasts one full period. A shifting state then moves one bit out per tick while a down-counter tracks the remaining bits. A stop state holds the line high, keeps busy asserted for one full tick period, and then returns to idle.

The asynchronous active-low reset is asserted at once and released through a short synchronizer. Load strobes that arrive while a frame is in progress are dropped.

Top module: `uart_tx_ld`

## Requirements
- R1: While reset is asserted, and directly after it, the serial line is 1 and busy is 0; asserting reset in the middle of a frame forces both at once, without waiting for a clock edge.
- R2: A load strobe seen in a clock cycle while idle captures the data byte in that cycle, and busy reads 1 from the following cycle.
- R3: After a capture, the line stays at 1 until the first baud tick; the cycle after that tick the line goes to 0, the start bit.
- R4: Each following tick advances the line by one bit: data bit 0 after the second tick, then bits 1 through 7 in order (least significant first), with the line holding its value between ticks.
- R5: The tick that ends data bit 7 sets the line to 1 (stop bit) while busy stays 1 for one full tick period.
- R6: The next tick after the stop bit begins clears busy, and a new load strobe is accepted in the very next cycle.
- R7: A load strobe while busy is 1 is ignored: the frame in progress keeps its byte and timing, and no second frame follows it.
- R8: While idle, baud ticks have no effect: the line stays 1 and busy stays 0.
- R9: The serial line changes value only in the cycle after a baud tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | One-cycle strobe requesting transmission of `data_i` |
| data_i | input | DATA_W | Byte to send, sampled in the cycle of an accepted strobe |
| bit_tick_i | input | 1 | One-cycle pulse marking each bit-period boundary |
| line_o | output | 1 | Serial line; 1 when quiet |
| busy_o | output | 1 | 1 from the cycle after a capture until the stop bit ends |

## Verification
The bench builds the block with its defaults, an eight-bit byte and a two-stage reset synchronizer, which keeps the whole data space small enough to send every one of the 256 byte values as a separate frame. Each frame is paced by bench-driven ticks, with the wait between capture and the first tick swept over zero, one and two cycles, so the case of a tick arriving in the very first preparation cycle is covered. Stray load strobes with inverted data are injected at varying bit positions of some frames, frames are sent back to back, and ticks are sent while idle; a reset asserted in mid-frame checks the asynchronous path and recovery.

// File: rtl/uart_tx_ld_pkg.sv
package uart_tx_ld_pkg;

  // Controller states; the encoding carries no meaning outside the block.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  // Assertion is immediate, release walks through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_ld_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  logic      tick_i,
  input  logic      last_bit_i,
  output tx_state_e state_o,
  output logic      capture_o,
  output logic      build_o,
  output logic      advance_o
);

  tx_state_e state_q;
  tx_state_e state_d;

  // Next-state decode.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_i)                state_d = ST_PREP;
      ST_PREP:  if (tick_i)                state_d = ST_SHIFT;
      ST_SHIFT: if (tick_i && last_bit_i)  state_d = ST_STOP;
      ST_STOP:  if (tick_i)                state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && load_i;
  assign build_o   = (state_q == ST_PREP);
  assign advance_o = (state_q == ST_SHIFT) && tick_i;

  // R2: a strobe in idle always leads to the preparation state.
  p_load_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && load_i) |=> (state_q == ST_PREP));

  // R7: while a frame runs, a strobe never restarts preparation.
  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SHIFT || state_q == ST_STOP) && load_i) |=> (state_q != ST_PREP));

  // R4/R5: the counter's last-bit flag ends shifting on that tick.
  p_shift_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && tick_i && last_bit_i) |=> (state_q == ST_STOP));

  // R6: stop lasts until a tick, then the block is idle again.
  p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && tick_i) |=> (state_q == ST_IDLE));

  // R5: without a tick the stop state holds.
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !tick_i) |=> (state_q == ST_STOP));

endmodule

// File: rtl/uart_tx_bitcnt.sv
module uart_tx_bitcnt #(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preset_i,
  input  logic dec_i,
  output logic last_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (preset_i) begin
      cnt_d = CNT_W'(FRAME_BITS);
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (preset_i || dec_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R4: the count never leaves the frame length.
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS));

  // R4: each shift step consumes exactly one count.
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !preset_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              build_i,
  input  logic              advance_i,
  output logic              bit_o
);

  localparam int SH_W = DATA_W + 1;

  logic [DATA_W-1:0] hold_q;
  logic [SH_W-1:0]   sh_q;
  logic [SH_W-1:0]   sh_d;

  // Byte holding register, enabled only by an accepted strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (capture_i) begin
      hold_q <= data_i;
    end
  end

  // Frame assembly places the start bit at the output end; shifting
  // moves toward bit 0 and back-fills with the idle level.
  always_comb begin
    sh_d = sh_q;
    if (build_i) begin
      sh_d = {hold_q, 1'b0};
    end else if (advance_i) begin
      sh_d = {1'b1, sh_q[SH_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (build_i || advance_i) begin
      sh_q <= sh_d;
    end
  end

  assign bit_o = sh_q[0];

  // R3: a freshly built frame starts with a low bit.
  p_frame_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    build_i |=> (sh_q[0] == 1'b0));

  // R7: the held byte is stable unless a strobe was accepted.
  p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_i && !build_i) |=> $stable(hold_q) || $past(capture_i));

endmodule

// File: rtl/uart_tx_ld.sv
module uart_tx_ld
  import uart_tx_ld_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_tick_i,
  output logic              line_o,
  output logic              busy_o
);

  localparam int FRAME_BITS = DATA_W + 1;

  logic      rst_n;
  tx_state_e state;
  logic      capture;
  logic      build;
  logic      advance;
  logic      last_bit;
  logic      ser_bit;

  uart_tx_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) rst_sync_i (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  uart_tx_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .tick_i     (bit_tick_i),
    .last_bit_i (last_bit),
    .state_o    (state),
    .capture_o  (capture),
    .build_o    (build),
    .advance_o  (advance)
  );

  uart_tx_bitcnt #(
    .FRAME_BITS (FRAME_BITS)
  ) bitcnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset_i (build),
    .dec_i    (advance),
    .last_o   (last_bit)
  );

  uart_tx_shifter #(
    .DATA_W (DATA_W)
  ) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .data_i    (data_i),
    .build_i   (build),
    .advance_i (advance),
    .bit_o     (ser_bit)
  );

  // Only the shifting state exposes the shift register.
  assign line_o = (state == ST_SHIFT) ? ser_bit : 1'b1;
  assign busy_o = (state != ST_IDLE);

  // R8: quiet line whenever the block is idle.
  p_idle_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);

  // R9: the line moves only right after a tick.
  p_line_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> $past(bit_tick_i));

  // R6: busy falls only on a tick.
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(bit_tick_i));

  // R2: busy rises only from an accepted strobe.
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(load_i));

endmodule

// File: tb/uart_tx_ld_tb_top.sv
module uart_tx_ld_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          load = 1'b0;
  logic          tick = 1'b0;
  logic [DW-1:0] din = '0;
  logic          line;
  logic          busy;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  uart_tx_ld #(
    .DATA_W      (DW),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk        (clk),
    .arst_n     (arst_n),
    .load_i     (load),
    .data_i     (din),
    .bit_tick_i (tick),
    .line_o     (line),
    .busy_o     (busy)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the tick edge.
  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // One full frame; poke selects the period (1..10) that gets a stray strobe, 0 for none.
  task automatic send_frame(input logic [DW-1:0] b, input int gap, input int poke);
    logic exp_line;
    din  = b;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    din  = ~b;
    chk("R2", "busy after strobe", busy, 1'b1);
    chk("R3", "line before first tick", line, 1'b1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R3", "line held in prep", line, 1'b1);
    end
    pulse_tick();
    chk("R3", "start bit", line, 1'b0);
    exp_line = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      if (k == poke) begin
        load = 1'b1;
        din  = ~b;
      end
      @(negedge clk);
      load = 1'b0;
      if (k == poke) begin
        chk("R7", "line after stray strobe", line, exp_line);
        chk("R7", "busy after stray strobe", busy, 1'b1);
      end else begin
        chk("R4", "line held between ticks", line, exp_line);
      end
      pulse_tick();
      if (k <= DW) begin
        exp_line = b[k-1];
        chk("R4", $sformatf("data bit %0d of %02h", k-1, b), line, exp_line);
        chk("R4", "busy during data", busy, 1'b1);
      end else if (k == DW + 1) begin
        exp_line = 1'b1;
        chk("R5", "stop bit level", line, 1'b1);
        chk("R5", "busy during stop", busy, 1'b1);
      end else begin
        chk("R6", "busy cleared after stop", busy, 1'b0);
        chk("R6", "line after stop", line, 1'b1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "line in reset", line, 1'b1);
    chk("R1", "busy in reset", busy, 1'b0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "line after reset", line, 1'b1);
    chk("R1", "busy after reset", busy, 1'b0);

    // R8: ticks while idle.
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R8", "line with idle tick", line, 1'b1);
      chk("R8", "busy with idle tick", busy, 1'b0);
    end

    // Every byte value, varying prep dwell and stray-strobe position.
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), v % 3, (v % 4 == 0) ? ((v / 4) % 10) + 1 : 0);
      if (v % 16 == 15) begin
        pulse_tick();
        chk("R7", "no second frame line", line, 1'b1);
        chk("R7", "no second frame busy", busy, 1'b0);
      end
    end

    // R1: asynchronous reset in mid-frame.
    din  = 8'h5A;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    pulse_tick();
    pulse_tick();
    pulse_tick();
    #2;
    arst_n = 1'b0;
    #1;
    chk("R1", "line on mid-frame reset", line, 1'b1);
    chk("R1", "busy on mid-frame reset", busy, 1'b0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'hC3, 1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 60000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule